// File: doc/BRIEF.md
# Page-Mode ROM Read Controller

This block connects a simple synchronous host read port to an external asynchronous page-mode ROM. It drives the ROM's chip enable, output enable, width-select and address pins. It counts wait states so that every returned datum has had its full access time before it is sampled. The host presents a request with an address and a width select. One cycle later the controller owns the access, and it answers with a single-cycle ready pulse carrying the captured data.

The controller remembers the page that is currently open. A page is the host address above bit 3, with bit 0 as the half-word select. When a later read falls in the same page, with the same width and with the chip still enabled, the controller changes only the low address lines and waits the short page time. In 16-bit mode, the ROM pin that carries data bit 31 becomes the lowest address bit, so the controller drives it and returns only the low 16 data bits.

A change of width closes the page and holds the chip disabled for the output-float time before the shared pin changes direction. A run of idle cycles also closes the page and puts the chip in standby.

Top module: `prom_page_reader`

## Requirements
- R1: After reset, chip enable and output enable are high (inactive), ready is low, the width pin is 1 (32-bit), and the A-1 pin is not driven.
- R2: A random read raises ready exactly RAND_W = ceil(T_RAND_NS/CLK_NS) cycles after the clock edge that accepts the request (24 at defaults). The returned data is what the ROM data pins hold at that edge. The address pins and the A-1 pin keep their values from acceptance until ready.
- R3: A request with the same host address bits [AW-1:4] and the same width, while the page is open, raises ready PAGE_W = ceil(T_PAGE_NS/CLK_NS) cycles after acceptance (6 at defaults), with chip enable held low throughout.
- R4: A request with the same width but a different page, while chip enable is low, keeps chip enable low and takes the random wait RAND_W.
- R5: With width select 1, the width pin is 1, the A-1 pin is not driven, host address bit 0 is ignored, and all 32 data bits are returned. With width select 0, the width pin is 0, the A-1 pin is driven with host address bit 0, and the data returned is {16'h0, ROM data bits 15:0}. The ROM address pins always carry host address bits [AW-1:1].
- R6: A request whose width differs from the current width while chip enable is low drives chip enable and output enable high for HIZ_W = ceil(T_HIZ_NS/CLK_NS) cycles (4 at defaults). The width pin then switches at the same edge that chip enable falls again, followed by a random wait. The width pin only ever changes after at least HIZ_W cycles with chip enable high.
- R7: If IDLE_CYC cycles (16 at defaults) follow a ready pulse with no request, chip enable and output enable go high after the IDLE_CYC-th edge. The next request is then a random read.
- R8: A request sampled at the same edge at which the idle count would expire is accepted as a normal open-page request, and chip enable stays low.
- R9: Ready is high for a single cycle per accepted request. Requests presented while a read or a turnaround is in progress are ignored and alter neither the pins nor the returned data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Read request, sampled only while idle |
| addr_i | input | AW | Host address in 16-bit units |
| wide_i | input | 1 | 1 = 32-bit read, 0 = 16-bit read |
| rdy_o | output | 1 | One-cycle pulse marking valid read data |
| rdata_o | output | 32 | Read data |
| rom_ce_n | output | 1 | ROM chip enable, active low |
| rom_oe_n | output | 1 | ROM output enable, active low |
| rom_dw_o | output | 1 | ROM width select, 1 = 32-bit |
| rom_a_o | output | AW-1 | ROM address pins |
| rom_d_i | input | 32 | ROM data pins |
| rom_am1_o | output | 1 | Value driven on the shared top data pin as A-1 |
| rom_am1_en_o | output | 1 | Drive enable for the shared top data pin |

## Verification
The sensitive collision is between idle expiry and a new request landing on the very edge where the idle count runs out. The controller must then serve the request from the open page rather than drop chip enable. The bench provokes this by waiting exactly IDLE_CYC-1 cycles after a ready pulse before raising the request, and a second case sits one cycle earlier. The behavioural model compares the chip enable pin and the ready timing on every clock, so it expects the short page latency with chip enable never released. A ROM model that returns a poison pattern until the page or random time has elapsed catches any early sample.

// File: rtl/prom_page_reader.sv
module prom_page_reader #(
  parameter int AW        = 23,
  parameter int CLK_NS    = 5,
  parameter int T_RAND_NS = 120,
  parameter int T_PAGE_NS = 30,
  parameter int T_HIZ_NS  = 20,
  parameter int IDLE_CYC  = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_i,
  input  logic [AW-1:0] addr_i,
  input  logic          wide_i,
  output logic          rdy_o,
  output logic [31:0]   rdata_o,
  output logic          rom_ce_n,
  output logic          rom_oe_n,
  output logic          rom_dw_o,
  output logic [AW-2:0] rom_a_o,
  input  logic [31:0]   rom_d_i,
  output logic          rom_am1_o,
  output logic          rom_am1_en_o
);
  localparam int RAND_W = (T_RAND_NS + CLK_NS - 1) / CLK_NS;
  localparam int PAGE_W = (T_PAGE_NS + CLK_NS - 1) / CLK_NS;
  localparam int HIZ_R  = (T_HIZ_NS + CLK_NS - 1) / CLK_NS;
  localparam int HIZ_W  = (HIZ_R < 1) ? 1 : HIZ_R;
  localparam int CMAX   = (RAND_W > IDLE_CYC) ? RAND_W : IDLE_CYC;
  localparam int CW     = $clog2(CMAX + 1);

  typedef enum logic [1:0] {S_OFF, S_OPEN, S_RUN, S_DRAIN} st_t;

  st_t            st;
  logic [CW-1:0]  cnt;
  logic           en_n_q, dw_q, pdw_q, pend_q, am1_q, pg_vld, rdy_q;
  logic [AW-2:0]  a_q;
  logic [AW-5:0]  pg_q;
  logic [31:0]    rdata_q;

  wire take = req_i && (st == S_OFF || st == S_OPEN);
  wire hit  = pg_vld && (addr_i[AW-1:4] == pg_q);

  assign rom_ce_n     = en_n_q;
  assign rom_oe_n     = en_n_q;
  assign rom_dw_o     = dw_q;
  assign rom_a_o      = a_q;
  assign rom_am1_o    = am1_q & ~dw_q;
  assign rom_am1_en_o = ~dw_q;
  assign rdy_o        = rdy_q;
  assign rdata_o      = rdata_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_OFF; cnt <= '0; en_n_q <= 1'b1; dw_q <= 1'b1; pdw_q <= 1'b1;
      pend_q <= 1'b0; am1_q <= 1'b0; pg_vld <= 1'b0; rdy_q <= 1'b0;
      a_q <= '0; pg_q <= '0; rdata_q <= '0;
    end else begin
      rdy_q <= 1'b0;
      if (take) begin
        a_q   <= addr_i[AW-1:1];
        am1_q <= addr_i[0];
        pg_q  <= addr_i[AW-1:4];
      end
      case (st)
        S_OFF: if (req_i) begin
          dw_q   <= wide_i;
          en_n_q <= 1'b0;
          cnt    <= CW'(RAND_W - 1);
          st     <= S_RUN;
        end
        S_OPEN: if (req_i) begin
          if (wide_i != dw_q) begin
            en_n_q <= 1'b1;
            pg_vld <= 1'b0;
            pdw_q  <= wide_i;
            pend_q <= 1'b1;
            cnt    <= CW'(HIZ_W - 1);
            st     <= S_DRAIN;
          end else begin
            cnt <= hit ? CW'(PAGE_W - 1) : CW'(RAND_W - 1);
            st  <= S_RUN;
          end
        end else if (cnt == '0) begin
          en_n_q <= 1'b1;
          pg_vld <= 1'b0;
          pend_q <= 1'b0;
          cnt    <= CW'(HIZ_W - 1);
          st     <= S_DRAIN;
        end else begin
          cnt <= cnt - 1'b1;
        end
        S_RUN: if (cnt == '0) begin
          rdata_q <= dw_q ? rom_d_i : {16'h0, rom_d_i[15:0]};
          rdy_q   <= 1'b1;
          pg_vld  <= 1'b1;
          cnt     <= CW'(IDLE_CYC - 1);
          st      <= S_OPEN;
        end else begin
          cnt <= cnt - 1'b1;
        end
        S_DRAIN: if (cnt == '0) begin
          if (pend_q) begin
            dw_q   <= pdw_q;
            en_n_q <= 1'b0;
            pend_q <= 1'b0;
            cnt    <= CW'(RAND_W - 1);
            st     <= S_RUN;
          end else begin
            st <= S_OFF;
          end
        end else begin
          cnt <= cnt - 1'b1;
        end
        default: st <= S_OFF;
      endcase
    end
  end

  a_r9_rdy_single: assert property (@(posedge clk) disable iff (!rst_n)
    rdy_o |=> !rdy_o);

  a_r2_pins_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_RUN) |=> ($stable(rom_a_o) && $stable(rom_am1_o)));

  a_r2_rdy_enabled: assert property (@(posedge clk) disable iff (!rst_n)
    rdy_o |-> !rom_ce_n);

  a_r6_width_in_standby: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(rom_dw_o) |-> $past(rom_ce_n));

  a_r7_page_closed: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rom_ce_n) |-> !pg_vld);
endmodule

// File: tb/tb_prom_page_reader.sv
`timescale 1ns/1ps
module tb_prom_page_reader;
  localparam int AW   = 23;
  localparam int RW   = (120 + 4) / 5;
  localparam int PW   = (30 + 4) / 5;
  localparam int HZ   = (20 + 4) / 5;
  localparam int IDLE = 16;

  logic clk = 1'b0, rst_n = 1'b0, req = 1'b0, wide = 1'b1;
  logic [AW-1:0] addr = '0;
  logic rdy, rom_ce_n, rom_oe_n, rom_dw, rom_am1, rom_am1_en;
  logic [31:0] rdata, rom_d;
  logic [AW-2:0] rom_a;

  prom_page_reader #(.AW(AW)) dut (
    .clk(clk), .rst_n(rst_n), .req_i(req), .addr_i(addr), .wide_i(wide),
    .rdy_o(rdy), .rdata_o(rdata), .rom_ce_n(rom_ce_n), .rom_oe_n(rom_oe_n),
    .rom_dw_o(rom_dw), .rom_a_o(rom_a), .rom_d_i(rom_d),
    .rom_am1_o(rom_am1), .rom_am1_en_o(rom_am1_en));

  always #2.5 clk = ~clk;

  int checks = 0, errors = 0, cyc = 0;

  function automatic logic [31:0] rom_dword(input logic [AW-2:0] a);
    return {a[15:0] ^ 16'hC3A5 ^ {10'd0, a[21:16]}, a[15:0] + 16'h1357};
  endfunction

  function automatic logic [31:0] exp_data(input logic [AW-1:0] a, input logic w);
    logic [31:0] d;
    d = rom_dword(a[AW-1:1]);
    return w ? d : {16'h0, a[0] ? d[31:16] : d[15:0]};
  endfunction

  // ROM timing model: poison until the access time has elapsed
  int c_full = 0, c_lo = 0, ce_hi_run = 0;
  logic [AW-1:0] hi_prev = '0;
  logic [3:0] lo_prev = '0;
  logic prev_dw = 1'b1;
  wire [AW-1:0] hi_now = {rom_ce_n, rom_oe_n, rom_dw, rom_a[AW-2:3]};
  wire [3:0] lo_now = {rom_a[2:0], rom_am1 & rom_am1_en};
  wire rom_ok = !rom_ce_n && !rom_oe_n && c_full >= RW && c_lo >= PW;
  wire [31:0] cur = rom_dword(rom_a);
  assign rom_d = !rom_ok ? 32'hBAD0_BAD0 :
                 rom_dw ? cur : {16'hEEEE, rom_am1 ? cur[31:16] : cur[15:0]};

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  // behavioural reference
  bit m_ce, m_mode, m_pgv, m_pend, m_pmode, e_rdy;
  int m_drain, m_busy, m_idle;
  logic [AW-5:0] m_pg;
  logic [AW-1:0] m_addr;
  logic [31:0] e_data;

  always @(negedge clk) begin
    cyc++;
    if (hi_now != hi_prev) c_full = 1; else if (c_full < 100000) c_full++;
    if (lo_now != lo_prev) c_lo = 1; else if (c_lo < 100000) c_lo++;
    hi_prev = hi_now;
    lo_prev = lo_now;
    if (rom_dw != prev_dw) chk(ce_hi_run >= HZ, "R6 width pin switched before float time", ce_hi_run, HZ);
    ce_hi_run = rom_ce_n ? ce_hi_run + 1 : 0;
    prev_dw = rom_dw;
    if (!rst_n) begin
      m_ce = 1; m_mode = 1; m_pgv = 0; m_pend = 0; m_pmode = 1; e_rdy = 0;
      m_drain = 0; m_busy = 0; m_idle = 0; m_pg = '0; m_addr = '0; e_data = '0;
    end else begin
      chk(rom_ce_n == m_ce, "R6/R7 chip enable (R3/R4 held low, R8)", rom_ce_n, m_ce);
      chk(rom_oe_n == m_ce, "R6/R7 output enable", rom_oe_n, m_ce);
      chk(rom_dw == m_mode, "R5 width pin", rom_dw, m_mode);
      chk(rom_am1_en == !m_mode, "R5 A-1 drive enable", rom_am1_en, !m_mode);
      chk(rom_am1 == (m_mode ? 1'b0 : m_addr[0]), "R5 A-1 value", rom_am1, m_mode ? 1'b0 : m_addr[0]);
      chk(rom_a == m_addr[AW-1:1], "R2 address pins", 32'(rom_a), 32'(m_addr[AW-1:1]));
      chk(rdy == e_rdy, "R9 ready pulse (R2/R3/R4/R8 latency)", rdy, e_rdy);
      if (e_rdy) chk(rdata == e_data, "R2/R3/R5 read data", rdata, e_data);
      e_rdy = 0;
      if (m_drain > 0) begin
        m_drain--;
        if (m_drain == 0 && m_pend) begin
          m_pend = 0; m_ce = 0; m_mode = m_pmode; m_busy = RW;
        end
      end else if (m_busy > 0) begin
        m_busy--;
        if (m_busy == 0) begin
          e_rdy = 1; e_data = exp_data(m_addr, m_mode); m_pgv = 1; m_idle = IDLE;
        end
      end else if (req) begin
        if (m_ce) begin
          m_ce = 0; m_mode = wide; m_busy = RW;
        end else if (wide != m_mode) begin
          m_ce = 1; m_pgv = 0; m_drain = HZ; m_pend = 1; m_pmode = wide;
        end else begin
          m_busy = (m_pgv && addr[AW-1:4] == m_pg) ? PW : RW;
        end
        m_addr = addr;
        m_pg = addr[AW-1:4];
      end else if (!m_ce) begin
        m_idle--;
        if (m_idle == 0) begin
          m_ce = 1; m_pgv = 0; m_drain = HZ; m_pend = 0;
        end
      end
    end
    if (cyc > 150000) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic rd(input logic [AW-1:0] a, input logic w, input int gap, input bit stray);
    repeat (gap) @(posedge clk);
    #1;
    req = 1'b1; addr = a; wide = w;
    @(posedge clk); #1;
    req = 1'b0;
    if (stray) begin
      @(posedge clk); #1;
      req = 1'b1; addr = ~a; wide = w;      // R9: ignored while busy
      @(posedge clk); #1;
      req = 1'b0;
    end
    for (int k = 0; k < 400; k++) begin
      if (rdy) break;
      @(posedge clk); #1;
    end
  endtask

  initial begin
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;
    chk(rom_ce_n && rom_oe_n, "R1 enables inactive after reset", {rom_ce_n, rom_oe_n}, 2'b11);
    chk(!rdy, "R1 ready low after reset", rdy, 0);
    chk(rom_dw && !rom_am1_en, "R1 width pin 32-bit, A-1 undriven", {rom_dw, rom_am1_en}, 2'b10);
    rd(23'h000100, 1'b1, 0, 1'b0);          // R2 random from standby
    rd(23'h000102, 1'b1, 0, 1'b0);          // R3 page hit
    rd(23'h00010F, 1'b1, 2, 1'b0);          // R3/R5 hit, bit 0 ignored
    rd(23'h000230, 1'b1, 0, 1'b0);          // R4 miss, ce held
    rd(23'h000231, 1'b0, 0, 1'b0);          // R6 width change, R5 word
    rd(23'h000230, 1'b0, 0, 1'b0);          // R3/R5 other half-word
    rd(23'h00023A, 1'b0, 1, 1'b1);          // R9 stray request
    rd(23'h000238, 1'b0, IDLE - 1, 1'b0);   // R8 request on expiry edge
    rd(23'h000237, 1'b0, IDLE - 2, 1'b0);   // R8 one cycle before expiry
    rd(23'h000501, 1'b0, IDLE + HZ + 2, 1'b0); // R7 after standby
    rd(23'h000501, 1'b1, 3, 1'b1);          // R6 back to 32-bit, R9 stray in float
    rd(23'h7FFFFF, 1'b1, 0, 1'b0);          // R4 top address
    rd(23'h7FFFF0, 1'b1, 0, 1'b0);          // R3 hit at top page
    rd(23'h000000, 1'b1, IDLE + HZ + 6, 1'b0); // R7 random from standby
    repeat (IDLE + HZ + 10) @(posedge clk);
    #1;
    chk(rom_ce_n, "R7 standby after idle", rom_ce_n, 1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule